// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

This block is a bus master that sends one frame from memory. Software writes the address of a six-word transmit descriptor into the pointer register. The engine then reads the descriptor through a 32-bit memory read port. Next it gathers two fragments, first a header and then a payload, and streams their bytes out on a valid/ready byte interface. When the descriptor has been consumed, the pointer register reads back as zero. Software polls that register to learn the transfer has finished.

A stall command can park the engine after a pointer has been accepted and before the descriptor is fetched. An unstall command lets the fetch begin. Each descriptor can ask for a transmit-complete indication. A misaligned pointer, or a pointer write made while a frame is in progress, sets a sticky error flag and is otherwise ignored.

The control is one state machine with eight states:

- IDLE: waits for a pointer write.
- PEND: holds while stalled.
- FETCH: reads the six descriptor words.
- SETUP: checks the current fragment length.
- FRAG_RD: reads one fragment word.
- FRAG_TX: serialises that word.
- ADVANCE: moves from the header to the payload, or ends the frame.
- FINISH: clears the pointer and pulses status.

The transitions are as follows:

- IDLE goes to PEND when an aligned pointer is written.
- PEND goes to FETCH when not stalled.
- FETCH goes to SETUP after the sixth read.
- SETUP goes to FRAG_RD if bytes remain, otherwise to ADVANCE.
- FRAG_RD goes to FRAG_TX on a read acknowledge.
- FRAG_TX goes back to FRAG_RD after its last byte if bytes remain, otherwise to ADVANCE.
- ADVANCE goes to SETUP for the payload, or to FINISH.
- FINISH goes to IDLE.

Top module: `tx_gather_dma`

## Requirements
- R1: An accepted pointer P causes exactly six descriptor reads at P, P+4, P+8, P+12, P+16, P+20, in that order and before any fragment read. The words are: next pointer (ignored), frame start word, header address, header length, payload address, payload length.
- R2: The bytes of the header fragment go out before the bytes of the payload fragment. Each fragment length is taken from bits 12:0 of its length word. Within each 32-bit word read from the fragment address, bytes leave least significant first.
- R3: If bit 31 of the header length word is set, the header is the last fragment and no payload byte is sent. `tx_last` is high on exactly one byte, the final byte of the frame.
- R4: A fragment whose length is zero is skipped without any memory read for it. A payload of length zero makes the header's final byte the frame's last byte.
- R5: `ptr_rdata` returns the accepted pointer while the frame is in progress. It reads zero from the cycle after the one-cycle `dn_complete` pulse, which marks the end of the frame.
- R6: `tx_done_ind` pulses together with `dn_complete` exactly when bit 15 of the frame start word is set. Otherwise it stays low.
- R7: A pointer write with any of bits 2:0 non-zero, made while idle, sets the sticky `err_align`. It causes no memory read and leaves the pointer reading zero.
- R8: A pointer write made while a frame is in progress is ignored and sets the sticky `err_busy`. The frame in progress completes from its original descriptor.
- R9: A command word with op field bits 15:11 equal to 6 and argument bits 10:0 equal to 2 stalls the engine. Op 6 with argument 3 releases it. While stalled, an accepted pointer is held and no memory read is made. A stall command given in the same cycle as a pointer write still holds that fetch.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays stable. No byte is lost or repeated under back-pressure.
- R11: After reset the pointer reads zero, `tx_valid`, `mem_req` and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer register write strobe |
| ptr_wdata | input | AW | Descriptor address to write |
| ptr_rdata | output | AW | Pointer readback, zero when idle |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Command: op in 15:11, argument in 10:0 |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | AW | Memory read byte address |
| mem_ack | input | 1 | Read acknowledge, data valid this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte stream valid |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream ready |
| dn_complete | output | 1 | One-cycle pulse at descriptor completion |
| tx_done_ind | output | 1 | One-cycle transmit-complete indication when requested |
| err_align | output | 1 | Sticky misaligned-pointer error |
| err_busy | output | 1 | Sticky write-while-busy error |

## Verification
Two events can fall in the same cycle. The first is a stall or unstall command arriving with the pointer write it is meant to gate. The second is a new pointer write landing while the engine is still moving bytes. The bench drives a stall command and a pointer write on the same clock edge, then confirms that no memory request appears for twenty cycles and that the pointer reads back the written value. It then releases the stall and compares the full byte stream. For the busy collision, it writes a second pointer during the transfer and judges that the read address log still starts at the first pointer, that the byte stream is intact and that `err_busy` is set.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_FETCH,
        ST_SETUP,
        ST_FRAG_RD,
        ST_FRAG_TX,
        ST_ADVANCE,
        ST_FINISH
    } txg_state_t;

    localparam logic [4:0]  OP_STALL      = 5'd6;
    localparam logic [10:0] ARG_HOLD      = 11'd2;
    localparam logic [10:0] ARG_RELEASE   = 11'd3;
    localparam int          DESC_WORDS    = 6;
    localparam int          ALIGN_BITS    = 3;
    localparam int          LAST_FLAG_BIT = 31;
    localparam int          IND_FLAG_BIT  = 15;

endpackage

// File: rtl/txg_stall_ctl.sv
module txg_stall_ctl
    import txg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    output logic        stalled
);

    logic [4:0]  op;
    logic [10:0] arg;
    logic        is_hold;
    logic        is_release;

    assign op         = cmd_word[15:11];
    assign arg        = cmd_word[10:0];
    assign is_hold    = cmd_valid && (op == OP_STALL) && (arg == ARG_HOLD);
    assign is_release = cmd_valid && (op == OP_STALL) && (arg == ARG_RELEASE);

    always_ff @(posedge clk) begin
        if (!rst_n)          stalled <= 1'b0;
        else if (is_hold)    stalled <= 1'b1;
        else if (is_release) stalled <= 1'b0;
    end

    // R9: a release command always leaves the engine free to fetch
    a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        is_release |=> !stalled);

endmodule

// File: rtl/txg_byte_ser.sv
module txg_byte_ser (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld,
    input  logic [31:0] ld_word,
    input  logic [2:0]  ld_cnt,
    input  logic        ld_last,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    output logic        done
);

    logic [31:0] shreg;
    logic [2:0]  cnt;
    logic        lastw;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            lastw <= 1'b0;
        end else if (ld) begin
            shreg <= ld_word;
            cnt   <= ld_cnt;
            lastw <= ld_last;
        end else if ((cnt != 3'd0) && tx_ready) begin
            shreg <= shreg >> 8;
            cnt   <= cnt - 3'd1;
        end
    end

    assign tx_valid = (cnt != 3'd0);
    assign tx_data  = shreg[7:0];
    assign tx_last  = lastw && (cnt == 3'd1);
    assign done     = tx_valid && tx_ready && (cnt == 3'd1);

    // R10: a byte held by back-pressure stays offered unchanged
    a_r10_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R2: the controller never reloads a word that is still being sent
    a_r2_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> !tx_valid);

endmodule

// File: rtl/tx_gather_dma.sv
module tx_gather_dma
    import txg_pkg::*;
#(
    parameter int AW   = 32,
    parameter int LENW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_wr,
    input  logic [AW-1:0] ptr_wdata,
    output logic [AW-1:0] ptr_rdata,
    input  logic          cmd_valid,
    input  logic [15:0]   cmd_word,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic          dn_complete,
    output logic          tx_done_ind,
    output logic          err_align,
    output logic          err_busy
);

    localparam int              IDXW     = $clog2(DESC_WORDS);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DESC_WORDS - 1);

    txg_state_t state, nxt;

    logic [AW-1:0]   ptr_q;
    logic [IDXW-1:0] widx;
    logic            ind_req_q;
    logic [AW-1:0]   haddr_q, daddr_q, faddr;
    logic [LENW-1:0] hlen_q, dlen_q, rem;
    logic            hlast_q;
    logic            frag_sel;
    logic            stalled;
    logic            ser_ld, ser_lastw, ser_done;
    logic [2:0]      ser_cnt;
    logic            misaligned, wr_ok, more_frag;

    assign misaligned = (ptr_wdata[ALIGN_BITS-1:0] != '0);
    assign wr_ok      = ptr_wr && (state == ST_IDLE) && !misaligned;
    assign more_frag  = !frag_sel && !hlast_q;

    txg_stall_ctl u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .stalled   (stalled)
    );

    txg_byte_ser u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ser_ld),
        .ld_word  (mem_rdata),
        .ld_cnt   (ser_cnt),
        .ld_last  (ser_lastw),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .done     (ser_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (wr_ok) nxt = ST_PEND;
            ST_PEND:    if (!stalled) nxt = ST_FETCH;
            ST_FETCH:   if (mem_ack && (widx == LAST_IDX)) nxt = ST_SETUP;
            ST_SETUP:   nxt = (rem != '0) ? ST_FRAG_RD : ST_ADVANCE;
            ST_FRAG_RD: if (mem_ack) nxt = ST_FRAG_TX;
            ST_FRAG_TX: if (ser_done) nxt = (rem != '0) ? ST_FRAG_RD : ST_ADVANCE;
            ST_ADVANCE: nxt = more_frag ? ST_SETUP : ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req     = (state == ST_FETCH) || (state == ST_FRAG_RD);
        mem_addr    = (state == ST_FETCH) ? (ptr_q + (AW'(widx) << 2)) : faddr;
        dn_complete = (state == ST_FINISH);
        tx_done_ind = (state == ST_FINISH) && ind_req_q;
        ser_ld      = (state == ST_FRAG_RD) && mem_ack;
        ser_cnt     = (rem >= LENW'(4)) ? 3'd4 : rem[2:0];
        ser_lastw   = (rem == LENW'(ser_cnt)) && (frag_sel || hlast_q || (dlen_q == '0));
        ptr_rdata   = ptr_q;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            widx      <= '0;
            ind_req_q <= 1'b0;
            haddr_q   <= '0;
            daddr_q   <= '0;
            hlen_q    <= '0;
            dlen_q    <= '0;
            hlast_q   <= 1'b0;
            frag_sel  <= 1'b0;
            rem       <= '0;
            faddr     <= '0;
            err_align <= 1'b0;
            err_busy  <= 1'b0;
        end else begin
            if (ptr_wr && (state != ST_IDLE)) err_busy  <= 1'b1;
            else if (ptr_wr && misaligned)     err_align <= 1'b1;
            if (wr_ok) begin
                ptr_q <= ptr_wdata;
                widx  <= '0;
            end
            if ((state == ST_FETCH) && mem_ack) begin
                widx <= widx + 1'b1;
                case (widx)
                    IDXW'(1): ind_req_q <= mem_rdata[IND_FLAG_BIT];
                    IDXW'(2): haddr_q   <= mem_rdata[AW-1:0];
                    IDXW'(3): begin
                        hlen_q  <= mem_rdata[LENW-1:0];
                        hlast_q <= mem_rdata[LAST_FLAG_BIT];
                    end
                    IDXW'(4): daddr_q   <= mem_rdata[AW-1:0];
                    IDXW'(5): dlen_q    <= mem_rdata[LENW-1:0];
                    default: ;
                endcase
                if (widx == LAST_IDX) begin
                    frag_sel <= 1'b0;
                    rem      <= hlen_q;
                    faddr    <= haddr_q;
                end
            end
            if (ser_ld) begin
                rem   <= rem - LENW'(ser_cnt);
                faddr <= faddr + AW'(4);
            end
            if ((state == ST_ADVANCE) && more_frag) begin
                frag_sel <= 1'b1;
                rem      <= dlen_q;
                faddr    <= daddr_q;
            end
            if (state == ST_FINISH) ptr_q <= '0;
        end
    end

    // R7: a misaligned pointer while idle raises the flag and starts no read
    a_r7_misaligned_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && misaligned && (state == ST_IDLE)) |=> (!mem_req && err_align));

    // R6: the transmit-complete indication only accompanies completion
    a_r6_ind_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_ind |-> dn_complete);

    // R5: the pointer reads zero right after completion
    a_r5_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        dn_complete |=> (ptr_rdata == '0));

    // R8: a write during a transfer flags the busy error
    a_r8_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && (state != ST_IDLE)) |=> err_busy);

    // R3: the last-byte marker only appears on a byte actually offered
    a_r3_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

endmodule

// File: tb/tx_gather_dma_test.sv
module tx_gather_dma_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ptr_wr;
    logic [31:0] ptr_wdata;
    logic [31:0] ptr_rdata;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    logic        mem_req, mem_ack;
    logic [31:0] mem_addr, mem_rdata;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  tx_data;
    logic        dn_complete, tx_done_ind, err_align, err_busy;

    always #5 clk = ~clk;

    logic [31:0] mem [64];
    logic        ack_en;
    logic        bp_mode;
    logic [15:0] lfsr;

    assign mem_ack   = mem_req & ack_en;
    assign mem_rdata = mem[mem_addr[7:2]];

    tx_gather_dma uut (
        .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
        .ptr_rdata(ptr_rdata), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .dn_complete(dn_complete),
        .tx_done_ind(tx_done_ind), .err_align(err_align), .err_busy(err_busy)
    );

    // back-pressure and memory latency pattern, driven after each edge
    always @(posedge clk) begin
        #1;
        lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = bp_mode ? lfsr[0] : 1'b1;
        ack_en   = bp_mode ? lfsr[3] : 1'b1;
    end

    int n_chk = 0, n_bad = 0;
    logic finished = 1'b0;
    int rx_n, last_n, last_pos, req_n, dn_n, ind_n, an, hold_bad;
    logic [7:0]  rx [256];
    logic [31:0] alog [16];
    logic        pv;
    logic [7:0]  pd;

    always @(negedge clk) begin
        if (tx_valid && tx_ready) begin
            if (rx_n < 256) rx[rx_n] = tx_data;
            if (tx_last) begin last_n++; last_pos = rx_n; end
            rx_n++;
        end
        if (pv && (!tx_valid || tx_data !== pd)) hold_bad++;
        pv = tx_valid && !tx_ready;
        pd = tx_data;
        if (mem_req) req_n++;
        if (mem_ack) begin if (an < 16) alog[an] = mem_addr; an++; end
        if (dn_complete) dn_n++;
        if (tx_done_ind) ind_n++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7) ^ 8'h3C);
    endfunction

    task automatic clear_logs();
        rx_n = 0; last_n = 0; last_pos = -1; req_n = 0;
        dn_n = 0; ind_n = 0; an = 0; hold_bad = 0; pv = 1'b0;
    endtask

    task automatic wr_ptr(input logic [31:0] v);
        @(posedge clk); #1;
        ptr_wr = 1'b1; ptr_wdata = v;
        @(posedge clk); #1;
        ptr_wr = 1'b0;
    endtask

    task automatic send_cmd(input logic [10:0] arg);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_word = {5'd6, arg};
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    // descriptor at 0x08, header bytes at 0x40, payload bytes at 0x80
    task automatic set_desc(input int hl, input int dl, input bit hlast, input bit cmpl);
        int total;
        total  = hl + (hlast ? 0 : dl);
        mem[2] = 32'h0;
        mem[3] = 32'(total) | (32'(cmpl) << 15);
        mem[4] = 32'h40;
        mem[5] = 32'(hl) | (32'(hlast) << 31);
        mem[6] = 32'h80;
        mem[7] = 32'(dl) | 32'h8000_0000;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4000 && dn_n == 0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_frame(input int hl, input int dl, input bit hlast, input bit cmpl);
        int total, bad, ok;
        total = hl + (hlast ? 0 : dl);
        ok = 1;
        for (int k = 0; k < 6; k++) if (alog[k] !== 32'(8 + 4 * k)) ok = 0;
        chk("R1 descriptor read order", ok, 1);
        chk("R2 byte count", rx_n, total);
        bad = 0;
        for (int i = 0; i < total && i < 256; i++)
            if (rx[i] !== ((i < hl) ? pat(64 + i) : pat(128 + i - hl))) bad++;
        chk("R2 byte order and values, mismatching bytes", bad, 0);
        chk("R3 count of last markers", last_n, (total > 0) ? 1 : 0);
        if (total > 0) chk("R3 last marker position", last_pos, total - 1);
        if (hl == 0 || dl == 0) chk("R4 zero-length fragment skipped, byte count", rx_n, total);
        chk("R5 pointer reads zero after done", int'(ptr_rdata), 0);
        chk("R5 one completion pulse", dn_n, 1);
        chk("R6 indication pulses", ind_n, int'(cmpl));
        chk("R10 data held under back-pressure, violations", hold_bad, 0);
    endtask

    // {bp, cmpl, hlast, data length, header length}
    localparam logic [18:0] VEC [6] = '{
        {1'b0, 1'b1, 1'b0, 8'd20, 8'd14},
        {1'b1, 1'b0, 1'b0, 8'd5,  8'd3 },
        {1'b0, 1'b1, 1'b1, 8'd10, 8'd8 },
        {1'b1, 1'b1, 1'b0, 8'd7,  8'd0 },
        {1'b1, 1'b0, 1'b0, 8'd64, 8'd14},
        {1'b0, 1'b1, 1'b0, 8'd0,  8'd5 }
    };

    initial begin
        lfsr = 16'hACE1; bp_mode = 1'b0; tx_ready = 1'b1; ack_en = 1'b1;
        ptr_wr = 1'b0; ptr_wdata = '0; cmd_valid = 1'b0; cmd_word = '0;
        for (int w = 0; w < 64; w++)
            mem[w] = {pat(4 * w + 3), pat(4 * w + 2), pat(4 * w + 1), pat(4 * w)};
        clear_logs();
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 pointer after reset", int'(ptr_rdata), 0);
        chk("R11 tx_valid after reset", int'(tx_valid), 0);
        chk("R11 mem_req after reset", int'(mem_req), 0);
        chk("R11 error flags after reset", int'({err_align, err_busy}), 0);

        // table of frames
        for (int v = 0; v < 6; v++) begin
            set_desc(int'(VEC[v][7:0]), int'(VEC[v][15:8]), VEC[v][16], VEC[v][17]);
            bp_mode = VEC[v][18];
            clear_logs();
            wr_ptr(32'h8);
            wait_done();
            check_frame(int'(VEC[v][7:0]), int'(VEC[v][15:8]), VEC[v][16], VEC[v][17]);
        end
        bp_mode = 1'b0;

        // R7 misaligned pointer
        clear_logs();
        wr_ptr(32'hC);
        repeat (5) @(negedge clk);
        chk("R7 err_align set", int'(err_align), 1);
        chk("R7 pointer stays zero", int'(ptr_rdata), 0);
        chk("R7 no memory read", req_n, 0);

        // R9 stall before the pointer write
        set_desc(14, 20, 1'b0, 1'b1);
        send_cmd(11'd2);
        clear_logs();
        wr_ptr(32'h8);
        repeat (20) @(negedge clk);
        chk("R9 no read while stalled", req_n, 0);
        chk("R5 pointer readback while held", int'(ptr_rdata), 8);
        send_cmd(11'd3);
        wait_done();
        check_frame(14, 20, 1'b0, 1'b1);

        // R9 stall command in the same cycle as the pointer write
        clear_logs();
        @(posedge clk); #1;
        ptr_wr = 1'b1; ptr_wdata = 32'h8;
        cmd_valid = 1'b1; cmd_word = {5'd6, 11'd2};
        @(posedge clk); #1;
        ptr_wr = 1'b0; cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9 same-cycle stall holds fetch", req_n, 0);
        chk("R9 pointer held", int'(ptr_rdata), 8);
        send_cmd(11'd3);
        wait_done();
        check_frame(14, 20, 1'b0, 1'b1);

        // R8 write while busy
        chk("R8 err_busy clear before test", int'(err_busy), 0);
        clear_logs();
        wr_ptr(32'h8);
        repeat (4) @(negedge clk);
        wr_ptr(32'h10);
        wait_done();
        chk("R8 err_busy set", int'(err_busy), 1);
        check_frame(14, 20, 1'b0, 1'b1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule